// File: doc/BRIEF.md
# Serial Flash Boot Fetcher

This block reads a configuration image out of an external serial flash right after reset, with no help from software. It leaves reset and wakes the flash from its low-power sleep with a single command byte. It then keeps the flash deselected for a settling interval, counted in system clock cycles, that covers a 10 µs minimum. After that it opens a second transaction: a fast-read command, a 24-bit start address, and eight dummy clocks. The image bytes that follow are handed downstream, one at a time, on a valid/ready byte port.

The serial side runs SPI mode 0 (clock idles low, data captured on the rising edge, most significant bit first). The serial clock is the system clock divided by `2*HALF_DIV`. When the downstream consumer holds off, the block parks the serial clock low between bytes with chip-select still asserted, so no byte is lost. Once the requested number of bytes has been accepted downstream, a one-cycle done pulse marks the end of the boot fetch. The block then stays idle until the next reset. The start address and byte count are inputs that must stay stable while reset is released.

Top module: `spi_boot_fetch`

## Requirements
- R1: The first transaction after reset carries exactly one byte, 0xAB, sent most significant bit first in SPI mode 0: `mosi` changes only while `sck` is low.
- R2: Between the wake transaction and the read transaction, `cs_n` stays high for at least `CLK_HZ*WAKE_NS/10^9` (rounded down) system clock cycles.
- R3: The read transaction starts with the byte 0x0B, followed by the 24-bit `load_addr`, most significant bit first.
- R4: Eight dummy clocks follow the address. `mosi` is low for the dummy clocks and for every data clock.
- R5: Each data byte is formed from `miso` sampled on the rising `sck` edges, most significant bit first. Bytes are delivered on `out_data` in flash address order. A byte stays on `out_data` with `out_valid` high until it is taken by `out_ready`.
- R6: While `out_valid` is high and `out_ready` is low, `sck` stays low.
- R7: Exactly `load_len` bytes are read and delivered. `cs_n` rises after the last byte has been received. `done` is high for exactly one cycle, in the cycle after the last byte is accepted.
- R8: With `load_len` equal to 0, the read transaction ends after the dummy clocks with no data clocks, no byte is delivered, and `done` pulses once.
- R9: `sck` is low whenever `cs_n` is high.
- R10: While `rst_n` is low, `cs_n` is high, `sck` is low, and `out_valid` and `done` are low.
- R11: After `done`, no further transaction starts and `out_valid` stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the fetch starts when it is released |
| load_addr | input | 24 | Flash byte address of the first image byte |
| load_len | input | LEN_W | Number of image bytes to fetch, captured as reset is released |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Command and address data to the flash |
| miso | input | 1 | Data from the flash |
| out_data | output | 8 | Image byte for the downstream consumer |
| out_valid | output | 1 | `out_data` holds a byte not yet accepted |
| out_ready | input | 1 | Downstream consumer accepts the byte |
| done | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The fetch is run with an always-ready consumer, a consumer that refuses every third cycle, and a consumer that stalls for dozens of cycles at a time. Comparing these runs separates a correct stall of the serial clock from dropped or duplicated bytes. Start addresses with all-ones upper bits and with alternating bit patterns show whether address bits are sent out of order or truncated. A start address near the top of the 24-bit space shows whether the fetch reads forward in flash address order from the programmed start. Lengths of 0, 1 and several bytes cover the dummy-only transaction, the immediate drain, and the steady stream. For each run, a behavioural flash model checks the captured command bytes and the deselect gap.

// File: rtl/fboot_pkg.sv
// Shared definitions for the serial flash boot fetcher.
// Assumes: flash understands the single-byte wake command and fast read.
package fboot_pkg;

    localparam logic [7:0] CMD_WAKE  = 8'hAB;
    localparam logic [7:0] CMD_FREAD = 8'h0B;
    localparam int unsigned ADDR_BYTES = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PAUSE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DRAIN,
        ST_END
    } boot_state_t;

endpackage

// File: rtl/fboot_byte_xfer.sv
// Moves one byte in SPI mode 0: eight sck pulses, MSB first.
// mosi changes only on the falling half; miso is captured on the rising half.
// Assumes: start is only raised while busy and done are low.
module fboot_byte_xfer #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       tx_sh;
    logic             half_tick;

    assign half_tick = (div_cnt == DIV_W'(HALF_DIV - 1));
    assign mosi      = busy ? tx_sh[7] : 1'b0;

    // Sequences the half periods of sck and shifts both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_byte <= '0;
            sck     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                sck     <= 1'b0;
                tx_sh   <= tx_byte;
                bit_idx <= '0;
                div_cnt <= '0;
            end else if (busy) begin
                if (!half_tick) begin
                    div_cnt <= div_cnt + 1'b1;
                end else begin
                    div_cnt <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fboot_settle_timer.sv
// Counts a fixed number of cycles while run is high; expired marks the last one.
// Assumes: CYCLES >= 1; dropping run restarts the count.
module fboot_settle_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_W'(CYCLES - 1));

    // Advances the count during run and clears it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/spi_boot_fetch.sv
// Boot-time fetch of an image from serial flash: wake command, settling gap
// with the flash deselected, fast read with 24-bit address and one dummy
// byte, then load_len bytes on a valid/ready port followed by a done pulse.
// Assumes: load_addr and load_len are stable while rst_n is released.
module spi_boot_fetch #(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned WAKE_NS  = 10_000,
    parameter int unsigned HALF_DIV = 4,
    parameter int unsigned LEN_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [23:0]      load_addr,
    input  logic [LEN_W-1:0] load_len,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             done
);
    import fboot_pkg::*;

    localparam int unsigned WAKE_RAW = (CLK_HZ / 1000) * WAKE_NS / 1_000_000;
    localparam int unsigned WAKE_CYC = (WAKE_RAW > 0) ? WAKE_RAW : 1;

    boot_state_t      state;
    logic [1:0]       addr_idx;
    logic [LEN_W-1:0] remaining;
    logic             pending;
    logic             in_xfer;
    logic             eng_start;
    logic [7:0]       eng_tx;
    logic             eng_busy;
    logic             eng_done;
    logic [7:0]       eng_rx;
    logic             wait_done;

    fboot_byte_xfer #(.HALF_DIV(HALF_DIV)) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    fboot_settle_timer #(.CYCLES(WAKE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_PAUSE),
        .expired (wait_done)
    );

    // Selects the states in which the flash is addressed.
    always_comb begin
        unique case (state)
            ST_WAKE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA: in_xfer = 1'b1;
            default:                                     in_xfer = 1'b0;
        endcase
    end

    assign cs_n = !in_xfer;
    assign eng_start = in_xfer && !eng_busy && !pending
                       && !(state == ST_DATA && out_valid);

    // Picks the byte sent in the current transfer step.
    always_comb begin
        unique case (state)
            ST_WAKE: eng_tx = CMD_WAKE;
            ST_CMD:  eng_tx = CMD_FREAD;
            ST_ADDR: begin
                unique case (addr_idx)
                    2'd0:    eng_tx = load_addr[23:16];
                    2'd1:    eng_tx = load_addr[15:8];
                    default: eng_tx = load_addr[7:0];
                endcase
            end
            default: eng_tx = 8'h00;
        endcase
    end

    // Sequencer: steps through the boot fetch and owns the output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_idx  <= '0;
            remaining <= '0;
            pending   <= 1'b0;
            out_data  <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (eng_start) begin
                pending <= 1'b1;
            end else if (eng_done) begin
                pending <= 1'b0;
            end
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    remaining <= load_len;
                    state     <= ST_WAKE;
                end
                ST_WAKE: if (eng_done) state <= ST_PAUSE;
                ST_PAUSE: if (wait_done) state <= ST_CMD;
                ST_CMD: if (eng_done) begin
                    addr_idx <= '0;
                    state    <= ST_ADDR;
                end
                ST_ADDR: if (eng_done) begin
                    if (addr_idx == 2'(ADDR_BYTES - 1)) begin
                        state <= ST_DUMMY;
                    end else begin
                        addr_idx <= addr_idx + 1'b1;
                    end
                end
                ST_DUMMY: if (eng_done) begin
                    if (remaining == '0) begin
                        state <= ST_END;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: if (eng_done) begin
                    out_data  <= eng_rx;
                    out_valid <= 1'b1;
                    remaining <= remaining - 1'b1;
                    if (remaining == LEN_W'(1)) state <= ST_DRAIN;
                end
                ST_DRAIN: if (out_valid && out_ready) begin
                    state <= ST_END;
                    done  <= 1'b1;
                end
                default: state <= ST_END;
            endcase
        end
    end

endmodule

// File: rtl/fboot_checker.sv
// Protocol checks for spi_boot_fetch, attached by bind.
// Assumes: the same CLK_HZ and WAKE_NS as the checked instance.
module fboot_checker #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned WAKE_NS = 10_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       done
);

    localparam logic [31:0] MIN_GAP = 32'((CLK_HZ / 1000) * WAKE_NS / 1_000_000);

    logic [31:0] high_run;
    logic [1:0]  falls;
    logic        cs_q;

    // Measures each deselected stretch and counts select edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_run <= '0;
            falls    <= '0;
            cs_q     <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                if (high_run != 32'hFFFF_FFFF) high_run <= high_run + 1'b1;
            end else begin
                high_run <= '0;
            end
            if (!cs_n && cs_q && falls != 2'd3) falls <= falls + 1'b1;
        end
    end

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi)); // R1
    AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && cs_q && falls == 2'd1) |-> (high_run >= MIN_GAP)); // R2
    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
    AST_STALL_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !sck); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R9

endmodule

bind spi_boot_fetch fboot_checker #(.CLK_HZ(CLK_HZ), .WAKE_NS(WAKE_NS)) u_chk (.*);

// File: tb/spi_boot_fetch_tb.sv
// Scoreboard bench: a run task queues the expected image bytes, a flash model
// answers on the serial pins, and a monitor pops and compares delivered bytes.
module spi_boot_fetch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned TB_CLK_HZ = 4_000_000;
    localparam int unsigned TB_WAKE_NS = 10_000;
    localparam int GAP_CYC = 40;     // 4 MHz * 10 us
    localparam int HDR_BITS = 40;    // command + address + dummy

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] load_addr = '0;
    logic [15:0] load_len = '0;
    logic        sck, cs_n, mosi, miso, out_valid, out_ready, done;
    logic [7:0]  out_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    int session, bitcnt, data_nz, gap_cnt, last_gap;
    int s1_bits, s2_bits, rx_cnt, done_cnt, done_rx, stall_bad, desel_bad;
    int rdy_ph, ready_mode;
    logic [39:0] hdr, s2_hdr;
    logic [7:0]  s1_byte;
    logic        sck_p, cs_p;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_boot_fetch #(
        .CLK_HZ(TB_CLK_HZ), .WAKE_NS(TB_WAKE_NS), .HALF_DIV(2), .LEN_W(16)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .load_len(load_len),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .done(done)
    );

    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Flash model, consumer and monitor, all evaluated on the falling clock edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            session = 0; bitcnt = 0; data_nz = 0; gap_cnt = 0; last_gap = 0;
            s1_bits = 0; s2_bits = 0; rx_cnt = 0; done_cnt = 0; done_rx = 0;
            stall_bad = 0; desel_bad = 0; rdy_ph = 0;
            hdr = '0; s2_hdr = '0; s1_byte = '0;
            sck_p = 1'b0; cs_p = 1'b1; miso = 1'b0; out_ready = 1'b0;
        end else begin
            rdy_ph++;
            case (ready_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = (rdy_ph % 3) != 0;
                default: out_ready = (rdy_ph % 64) >= 50;
            endcase
            if (cs_n) gap_cnt++;
            if (!cs_n && cs_p) begin
                session++;
                bitcnt = 0;
                hdr = '0;
                if (session == 2) last_gap = gap_cnt;
                gap_cnt = 0;
            end
            if (cs_n && !cs_p) begin
                if (session == 1) begin s1_bits = bitcnt; s1_byte = hdr[7:0]; end
                if (session == 2) begin s2_bits = bitcnt; s2_hdr = hdr; end
            end
            if (sck && !sck_p && !cs_n) begin
                if (bitcnt < HDR_BITS) hdr = {hdr[38:0], mosi};
                else if (mosi) data_nz++;
                bitcnt++;
            end
            if (!sck && sck_p && !cs_n && session == 2 && bitcnt >= HDR_BITS) begin
                logic [7:0] fb;
                fb = flash_byte(load_addr + 24'((bitcnt - HDR_BITS) / 8));
                miso = fb[7 - ((bitcnt - HDR_BITS) % 8)];
            end
            sck_p = sck;
            cs_p = cs_n;
            if (out_valid && !out_ready && sck) stall_bad++;
            if (cs_n && sck) desel_bad++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R5", "data byte", out_data, e);
                end
                rx_cnt++;
            end
            if (done) begin
                done_cnt++;
                done_rx = rx_cnt;
            end
        end
    end

    // One boot fetch from reset to idle, with all end-of-run checks.
    task automatic run(input logic [23:0] addr, input int len, input int mode);
        int t;
        string rq;
        rq = (len == 0) ? "R8" : "R7";
        ready_mode = mode;
        load_addr = addr;
        load_len = 16'(len);
        rst_n = 1'b0;
        exp_q.delete();
        for (int k = 0; k < len; k++) exp_q.push_back(flash_byte(addr + 24'(k)));
        repeat (3) @(negedge clk);
        check(cs_n && !sck && !out_valid && !done, "R10", "reset outputs",
              {cs_n, sck, out_valid, done}, 4'b1000);
        rst_n = 1'b1;
        t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(posedge clk);
            t++;
        end
        check(t < 20000, rq, "done seen", t, 0);
        repeat (100) @(negedge clk);
        @(posedge clk);
        check(s1_bits == 8, "R1", "wake length", s1_bits, 8);
        check(s1_byte == 8'hAB, "R1", "wake byte", s1_byte, 8'hAB);
        check(last_gap >= GAP_CYC, "R2", "deselect gap", last_gap, GAP_CYC);
        check(s2_hdr[39:32] == 8'h0B, "R3", "read command", s2_hdr[39:32], 8'h0B);
        check(s2_hdr[31:8] == addr, "R3", "address", s2_hdr[31:8], addr);
        check(s2_hdr[7:0] == 8'h00 && data_nz == 0, "R4", "dummy/data mosi",
              {s2_hdr[7:0], 8'(data_nz)}, 0);
        check(s2_bits == HDR_BITS + 8 * len, rq, "read clocks", s2_bits,
              HDR_BITS + 8 * len);
        check(rx_cnt == len && exp_q.size() == 0, "R5", "bytes delivered",
              rx_cnt, len);
        check(done_cnt == 1 && done_rx == len, rq, "done pulse", done_cnt, 1);
        check(stall_bad == 0, "R6", "sck during stall", stall_bad, 0);
        check(desel_bad == 0, "R9", "sck while deselected", desel_bad, 0);
        check(session == 2 && cs_n && !sck && !out_valid, "R11", "idle after done",
              session, 2);
    endtask

    initial begin
        ready_mode = 0;
        run(24'h123456, 5, 0);
        run(24'hFFFFFE, 4, 1);
        run(24'h00A0F0, 0, 0);
        run(24'h3C3C3C, 3, 2);
        run(24'hA5A5A5, 1, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule